// File: doc/BRIEF.md
# DDR3 ODT Power-Down Transition Tracker

This block sits on the controller side of a DDR3 interface and watches four things: the registered clock-enable, the on-die-termination control pin, refresh command issue and the mode-register setting that chooses whether the DLL is frozen during precharge power-down. For every change of the termination control pin it states how the memory's termination will follow that change. The change can be synchronous (timed from the write-latency-derived ODT latency), asynchronous (timed by the power-down delays), or uncertain, because it falls inside the transition window around power-down entry, where either behaviour may occur.

The window opens a fixed number of cycles before clock-enable is first seen low, so an edge cannot be classified when it happens. Every edge is held in a short history for WL-1 cycles. When clock-enable falls, the recorded edges that now lie inside the window are reclassified. A refresh that is still busy when clock-enable falls can stretch the end of the window. With each result the block also reports the earliest and latest cycle at which the termination may change. Both are integer cycle offsets from the edge cycle, and they are derived from timing inputs given in clock cycles.

Top module: `odt_pd_tracker`

## Requirements
- R1: A synchronous active-high `rst` drives every result output to zero and clears the edge history, the refresh timer and the window state, so an edge recorded before reset is never reported.
- R2: Each change of `odt` is reported exactly once. An edge is a value differing from the previous clock's sample. Its result pulses `res_valid` for one cycle, exactly `cfg_wl` cycles after the edge cycle, with `res_rise`=1 for a low-to-high change and 0 for high-to-low.
- R3: `res_kind` encodes 0 = synchronous, 1 = uncertain, 2 = asynchronous, and never shows 3. Any edge outside the transition window and outside power-down is synchronous.
- R4: Let t0 be the first cycle in which `cke` is sampled low after being high. When `dll_keep_on`=0, an edge in cycle t0-(WL-1) is synchronous, and edges in cycles t0-(WL-2) through t0 are uncertain. These earlier edges are reclassified retroactively.
- R5: With no refresh busy at t0, the window ends at cycle t0+`cfg_pd_entry`-1, and that cycle is included. Later edges while `cke` stays low are asynchronous.
- R6: A refresh issued in cycle r is busy at t0 when r+`cfg_ref_busy` > t0. In that case the window ends at the later of t0+`cfg_pd_entry`-1 and r+`cfg_ref_busy`, and the end cycle is included. A refresh that finished earlier has no effect.
- R7: When `dll_keep_on`=1 in the cycle `cke` falls, no window is opened and every edge is reported synchronous.
- R8: Bounds for a rising edge: synchronous gives [on_lat+on_skew_min, on_lat+on_skew_max]; asynchronous gives [pd_on_min, pd_on_max]; uncertain gives the smaller of the two minimums and the larger of the two maximums. Falling edges use the off set of inputs in the same way.
- R9: Once `cke` returns high, the window state returns to idle, and later edges are synchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Registered clock-enable as sent to the memory |
| odt | input | 1 | Termination control pin as sent to the memory |
| ref_issue | input | 1 | High in the cycle a refresh command is issued |
| dll_keep_on | input | 1 | Mode-register DLL power-down bit: 0 freezes the DLL (window tracked), 1 keeps it running |
| cfg_wl | input | CW | Write latency in cycles (2 to WL_MAX) |
| cfg_on_lat | input | CW | Synchronous turn-on latency in cycles |
| cfg_off_lat | input | CW | Synchronous turn-off latency in cycles |
| cfg_on_skew_min | input | CW | Synchronous turn-on skew, minimum |
| cfg_on_skew_max | input | CW | Synchronous turn-on skew, maximum |
| cfg_off_skew_min | input | CW | Synchronous turn-off skew, minimum |
| cfg_off_skew_max | input | CW | Synchronous turn-off skew, maximum |
| cfg_pd_on_min | input | CW | Asynchronous power-down turn-on delay, minimum |
| cfg_pd_on_max | input | CW | Asynchronous power-down turn-on delay, maximum |
| cfg_pd_off_min | input | CW | Asynchronous power-down turn-off delay, minimum |
| cfg_pd_off_max | input | CW | Asynchronous power-down turn-off delay, maximum |
| cfg_pd_entry | input | CW | Minimum clock-enable-low to power-down entry period in cycles (at least 1) |
| cfg_ref_busy | input | TW | Refresh busy time in cycles (at least 1) |
| res_valid | output | 1 | One-cycle pulse: a result is presented |
| res_rise | output | 1 | 1 for a rising edge, 0 for a falling edge |
| res_kind | output | 2 | Classification (0 sync, 1 uncertain, 2 async) |
| res_early | output | CW+1 | Earliest termination change, cycles after the edge |
| res_late | output | CW+1 | Latest termination change, cycles after the edge |

## Verification
The hardest situations to reach are the two boundaries of the window. One is an edge exactly WL-1 cycles before the clock-enable fall, which must stay synchronous while its successor one cycle later is promoted. The other is a refresh still busy at the fall, which pushes the end of the window past the entry period. Each scenario runs from a fresh reset with a per-step timeline that places the clock-enable fall, the refresh and both termination edges at chosen offsets from one another. Because results lag by the write latency, the bench time-stamps every result and matches it against the edge cycle plus WL.

// File: rtl/odt_trk_pkg.sv
package odt_trk_pkg;

    localparam int CFG_W_D  = 6;
    localparam int TMR_W_D  = 9;
    localparam int WL_MAX_D = 16;

    typedef enum logic [1:0] {
        ODT_SYNC   = 2'd0,
        ODT_UNSURE = 2'd1,
        ODT_ASYNC  = 2'd2
    } odt_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WIN  = 2'd1,
        PH_PD   = 2'd2
    } pd_phase_e;

    typedef struct packed {
        logic      vld;
        logic      rise;
        odt_kind_e kind;
    } hist_ent_t;

    // Mark a recorded edge as uncertain when the window reaches back over it.
    function automatic hist_ent_t promote(input hist_ent_t e, input logic en);
        hist_ent_t r;
        r = e;
        if (en && e.vld) r.kind = ODT_UNSURE;
        return r;
    endfunction

endpackage

// File: rtl/odt_win_fsm.sv
module odt_win_fsm
    import odt_trk_pkg::*;
#(
    parameter int CW = CFG_W_D,
    parameter int TW = TMR_W_D
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cke,
    input  logic          ref_issue,
    input  logic          dll_keep_on,
    input  logic [CW-1:0] cfg_pd_entry,
    input  logic [TW-1:0] cfg_ref_busy,
    output pd_phase_e     phase,
    output logic [TW-1:0] win_cnt,
    output logic          win_open
);

    logic          cke_q;
    logic [TW-1:0] rfc_cnt;
    logic [TW-1:0] rfc_rem;
    logic [TW-1:0] pd_last;
    logic [TW-1:0] win_left;

    // Cycles of refresh still outstanding beyond the current one.
    assign rfc_rem  = ref_issue ? cfg_ref_busy : rfc_cnt;
    assign pd_last  = TW'(cfg_pd_entry) - TW'(1);
    assign win_left = (rfc_rem > pd_last) ? rfc_rem : pd_last;
    assign win_open = (phase == PH_IDLE) && cke_q && !cke && !dll_keep_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q   <= 1'b1;
            rfc_cnt <= '0;
        end else begin
            cke_q <= cke;
            if (ref_issue)
                rfc_cnt <= cfg_ref_busy - TW'(1);
            else if (rfc_cnt != '0)
                rfc_cnt <= rfc_cnt - TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            win_cnt <= '0;
        end else if (cke) begin
            phase   <= PH_IDLE;
            win_cnt <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (win_open) begin
                        phase   <= (win_left == '0) ? PH_PD : PH_WIN;
                        win_cnt <= win_left;
                    end
                end
                PH_WIN: begin
                    if (win_cnt <= TW'(1)) begin
                        phase   <= PH_PD;
                        win_cnt <= '0;
                    end else begin
                        win_cnt <= win_cnt - TW'(1);
                    end
                end
                default: phase <= PH_PD;
            endcase
        end
    end

endmodule

// File: rtl/odt_edge_hist.sv
module odt_edge_hist
    import odt_trk_pkg::*;
#(
    parameter int CW    = CFG_W_D,
    parameter int DEPTH = WL_MAX_D - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  hist_ent_t     ins,
    input  logic          reclass,
    input  logic [CW-1:0] cfg_wl,
    output hist_ent_t     tap
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    hist_ent_t       st [DEPTH];
    logic [CW-1:0]   lag;
    logic [IW-1:0]   tap_idx;

    // Stage k holds the edge of k+1 cycles ago; the edge of WL-1 cycles ago is read out.
    assign lag = cfg_wl - CW'(2);

    always_comb begin
        if (lag >= CW'(DEPTH)) tap_idx = IW'(DEPTH - 1);
        else                   tap_idx = IW'(lag);
    end

    assign tap = st[tap_idx];

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) st[k] <= '0;
                else     st[k] <= ins;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) st[k] <= '0;
                else     st[k] <= promote(st[k-1], reclass && (CW'(k - 1) < lag));
            end
        end
    end

endmodule

// File: rtl/odt_bound_calc.sv
module odt_bound_calc
    import odt_trk_pkg::*;
#(
    parameter int CW = CFG_W_D,
    localparam int BW = CW + 1
) (
    input  logic          rise,
    input  odt_kind_e     kind,
    input  logic [CW-1:0] cfg_on_lat,
    input  logic [CW-1:0] cfg_off_lat,
    input  logic [CW-1:0] cfg_on_skew_min,
    input  logic [CW-1:0] cfg_on_skew_max,
    input  logic [CW-1:0] cfg_off_skew_min,
    input  logic [CW-1:0] cfg_off_skew_max,
    input  logic [CW-1:0] cfg_pd_on_min,
    input  logic [CW-1:0] cfg_pd_on_max,
    input  logic [CW-1:0] cfg_pd_off_min,
    input  logic [CW-1:0] cfg_pd_off_max,
    output logic [BW-1:0] early,
    output logic [BW-1:0] late
);

    logic [BW-1:0] s_lo, s_hi, a_lo, a_hi;

    always_comb begin
        if (rise) begin
            s_lo = BW'(cfg_on_lat) + BW'(cfg_on_skew_min);
            s_hi = BW'(cfg_on_lat) + BW'(cfg_on_skew_max);
            a_lo = BW'(cfg_pd_on_min);
            a_hi = BW'(cfg_pd_on_max);
        end else begin
            s_lo = BW'(cfg_off_lat) + BW'(cfg_off_skew_min);
            s_hi = BW'(cfg_off_lat) + BW'(cfg_off_skew_max);
            a_lo = BW'(cfg_pd_off_min);
            a_hi = BW'(cfg_pd_off_max);
        end
        unique case (kind)
            ODT_ASYNC: begin
                early = a_lo;
                late  = a_hi;
            end
            ODT_UNSURE: begin
                early = (s_lo < a_lo) ? s_lo : a_lo;
                late  = (s_hi > a_hi) ? s_hi : a_hi;
            end
            default: begin
                early = s_lo;
                late  = s_hi;
            end
        endcase
    end

endmodule

// File: rtl/odt_pd_tracker.sv
module odt_pd_tracker
    import odt_trk_pkg::*;
#(
    parameter int CW     = CFG_W_D,
    parameter int TW     = TMR_W_D,
    parameter int WL_MAX = WL_MAX_D,
    localparam int BW    = CW + 1,
    localparam int DEPTH = WL_MAX - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cke,
    input  logic          odt,
    input  logic          ref_issue,
    input  logic          dll_keep_on,
    input  logic [CW-1:0] cfg_wl,
    input  logic [CW-1:0] cfg_on_lat,
    input  logic [CW-1:0] cfg_off_lat,
    input  logic [CW-1:0] cfg_on_skew_min,
    input  logic [CW-1:0] cfg_on_skew_max,
    input  logic [CW-1:0] cfg_off_skew_min,
    input  logic [CW-1:0] cfg_off_skew_max,
    input  logic [CW-1:0] cfg_pd_on_min,
    input  logic [CW-1:0] cfg_pd_on_max,
    input  logic [CW-1:0] cfg_pd_off_min,
    input  logic [CW-1:0] cfg_pd_off_max,
    input  logic [CW-1:0] cfg_pd_entry,
    input  logic [TW-1:0] cfg_ref_busy,
    output logic          res_valid,
    output logic          res_rise,
    output logic [1:0]    res_kind,
    output logic [BW-1:0] res_early,
    output logic [BW-1:0] res_late
);

    logic          odt_q;
    pd_phase_e     phase_w;
    logic [TW-1:0] win_cnt_w;
    logic          win_open_w;
    hist_ent_t     new_ent;
    hist_ent_t     tap_ent;
    logic [BW-1:0] early_w, late_w;

    always_ff @(posedge clk) begin
        if (rst) odt_q <= 1'b0;
        else     odt_q <= odt;
    end

    odt_win_fsm #(.CW(CW), .TW(TW)) u_win (
        .clk          (clk),
        .rst          (rst),
        .cke          (cke),
        .ref_issue    (ref_issue),
        .dll_keep_on  (dll_keep_on),
        .cfg_pd_entry (cfg_pd_entry),
        .cfg_ref_busy (cfg_ref_busy),
        .phase        (phase_w),
        .win_cnt      (win_cnt_w),
        .win_open     (win_open_w)
    );

    // Tag an edge by the phase of the cycle it occurs in.
    always_comb begin
        new_ent.vld  = odt ^ odt_q;
        new_ent.rise = odt & ~odt_q;
        if (win_open_w || phase_w == PH_WIN) new_ent.kind = ODT_UNSURE;
        else if (phase_w == PH_PD)           new_ent.kind = ODT_ASYNC;
        else                                 new_ent.kind = ODT_SYNC;
    end

    odt_edge_hist #(.CW(CW), .DEPTH(DEPTH)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .ins     (new_ent),
        .reclass (win_open_w),
        .cfg_wl  (cfg_wl),
        .tap     (tap_ent)
    );

    odt_bound_calc #(.CW(CW)) u_bound (
        .rise             (tap_ent.rise),
        .kind             (tap_ent.kind),
        .cfg_on_lat       (cfg_on_lat),
        .cfg_off_lat      (cfg_off_lat),
        .cfg_on_skew_min  (cfg_on_skew_min),
        .cfg_on_skew_max  (cfg_on_skew_max),
        .cfg_off_skew_min (cfg_off_skew_min),
        .cfg_off_skew_max (cfg_off_skew_max),
        .cfg_pd_on_min    (cfg_pd_on_min),
        .cfg_pd_on_max    (cfg_pd_on_max),
        .cfg_pd_off_min   (cfg_pd_off_min),
        .cfg_pd_off_max   (cfg_pd_off_max),
        .early            (early_w),
        .late             (late_w)
    );

    always_ff @(posedge clk) begin
        if (rst || !tap_ent.vld) begin
            res_valid <= 1'b0;
            res_rise  <= 1'b0;
            res_kind  <= 2'd0;
            res_early <= '0;
            res_late  <= '0;
        end else begin
            res_valid <= 1'b1;
            res_rise  <= tap_ent.rise;
            res_kind  <= tap_ent.kind;
            res_early <= early_w;
            res_late  <= late_w;
        end
    end

endmodule

// File: rtl/odt_pd_tracker_chk.sv
module odt_pd_tracker_chk
    import odt_trk_pkg::*;
#(
    parameter int CW = CFG_W_D,
    parameter int TW = TMR_W_D,
    localparam int BW = CW + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          cke,
    input logic          dll_keep_on,
    input logic          res_valid,
    input logic          res_rise,
    input logic [1:0]    res_kind,
    input logic [BW-1:0] res_early,
    input logic [BW-1:0] res_late,
    input logic [CW-1:0] cfg_on_lat,
    input logic [CW-1:0] cfg_on_skew_min,
    input logic [CW-1:0] cfg_on_skew_max,
    input logic [CW-1:0] cfg_pd_on_min,
    input logic [CW-1:0] cfg_pd_on_max,
    input pd_phase_e     phase,
    input logic [TW-1:0] win_cnt
);

    logic          chk_cke_d;
    logic [BW-1:0] on_lo, on_hi;

    assign on_lo = BW'(cfg_on_lat) + BW'(cfg_on_skew_min);
    assign on_hi = BW'(cfg_on_lat) + BW'(cfg_on_skew_max);

    always_ff @(posedge clk) begin
        if (rst) chk_cke_d <= 1'b1;
        else     chk_cke_d <= cke;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !res_valid);

    assert_kind_legal_R3: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_kind != 2'd3));

    assert_fall_opens_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && chk_cke_d && !cke && !dll_keep_on) |=> (phase != PH_IDLE));

    assert_window_live_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WIN) |-> (win_cnt != '0));

    assert_dll_on_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && dll_keep_on) |=> (phase == PH_IDLE));

    assert_unsure_span_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_rise && res_kind == 2'd1) |->
        (res_early <= on_lo && res_early <= BW'(cfg_pd_on_min) &&
         res_late >= on_hi && res_late >= BW'(cfg_pd_on_max)));

    assert_exit_idle_R9: assert property (@(posedge clk) disable iff (rst)
        cke |=> (phase == PH_IDLE));

endmodule

bind odt_pd_tracker odt_pd_tracker_chk #(.CW(CW), .TW(TW)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cke             (cke),
    .dll_keep_on     (dll_keep_on),
    .res_valid       (res_valid),
    .res_rise        (res_rise),
    .res_kind        (res_kind),
    .res_early       (res_early),
    .res_late        (res_late),
    .cfg_on_lat      (cfg_on_lat),
    .cfg_on_skew_min (cfg_on_skew_min),
    .cfg_on_skew_max (cfg_on_skew_max),
    .cfg_pd_on_min   (cfg_pd_on_min),
    .cfg_pd_on_max   (cfg_pd_on_max),
    .phase           (phase_w),
    .win_cnt         (win_cnt_w)
);

// File: tb/sim_odt_pd_tracker.sv
module sim_odt_pd_tracker;

    localparam int CW = 6;
    localparam int TW = 9;
    localparam int BW = CW + 1;
    localparam int WL = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cke = 1'b1;
    logic          odt = 1'b0;
    logic          ref_issue = 1'b0;
    logic          dll_keep_on = 1'b0;
    logic          res_valid, res_rise;
    logic [1:0]    res_kind;
    logic [BW-1:0] res_early, res_late;

    int checks = 0;
    int fails  = 0;
    int cnt    = 0;
    int got_n  = 0;
    int got_kind [8];
    int got_rise [8];
    int got_early[8];
    int got_late [8];
    int got_t    [8];

    always #2 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 1;

    odt_pd_tracker #(.CW(CW), .TW(TW), .WL_MAX(16)) u0 (
        .clk(clk), .rst(rst), .cke(cke), .odt(odt), .ref_issue(ref_issue),
        .dll_keep_on(dll_keep_on),
        .cfg_wl(CW'(WL)), .cfg_on_lat(CW'(4)), .cfg_off_lat(CW'(4)),
        .cfg_on_skew_min(CW'(0)), .cfg_on_skew_max(CW'(1)),
        .cfg_off_skew_min(CW'(0)), .cfg_off_skew_max(CW'(1)),
        .cfg_pd_on_min(CW'(6)), .cfg_pd_on_max(CW'(9)),
        .cfg_pd_off_min(CW'(6)), .cfg_pd_off_max(CW'(10)),
        .cfg_pd_entry(CW'(4)), .cfg_ref_busy(TW'(20)),
        .res_valid(res_valid), .res_rise(res_rise), .res_kind(res_kind),
        .res_early(res_early), .res_late(res_late)
    );

    // Result monitor: stamps every reported edge with the bench cycle count.
    always @(negedge clk) begin
        if (!rst && res_valid && got_n < 8) begin
            got_kind[got_n]  = int'(res_kind);
            got_rise[got_n]  = int'(res_rise);
            got_early[got_n] = int'(res_early);
            got_late[got_n]  = int'(res_late);
            got_t[got_n]     = cnt;
            got_n            = got_n + 1;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cke = 1'b1; odt = 1'b0; ref_issue = 1'b0; dll_keep_on = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        got_n = 0;
    endtask

    task automatic chk_count(input string rq, input int exp_n);
        checks++;
        if (got_n != exp_n) begin
            fails++;
            $display("FAIL %s result count: actual %0d expected %0d", rq, got_n, exp_n);
        end
    endtask

    task automatic chk_res(input int idx, input string rq, input int ek, input int er,
                           input int ee, input int el, input int et);
        checks++;
        if (idx >= got_n) begin
            fails++;
            $display("FAIL %s result %0d missing: actual count %0d expected kind %0d", rq, idx, got_n, ek);
        end else if (got_kind[idx] != ek || got_rise[idx] != er || got_early[idx] != ee ||
                     got_late[idx] != el || got_t[idx] != et) begin
            fails++;
            $display("FAIL %s result %0d: actual kind %0d rise %0d [%0d,%0d] t %0d expected kind %0d rise %0d [%0d,%0d] t %0d",
                     rq, idx, got_kind[idx], got_rise[idx], got_early[idx], got_late[idx], got_t[idx],
                     ek, er, ee, el, et);
        end
    endtask

    // Per-step timeline; returns the cycle count at step 0. Negative step = event absent.
    task automatic scen(input int dll, input int fall_at, input int up_at, input int ref_at,
                        input int on_at, input int off_at, input int len, output int base);
        do_reset();
        dll_keep_on = dll[0];
        base = cnt;
        for (int i = 0; i < len; i++) begin
            cke = !(fall_at >= 0 && i >= fall_at && (up_at < 0 || i < up_at));
            ref_issue = (i == ref_at);
            odt = (on_at >= 0 && i >= on_at && (off_at < 0 || i < off_at));
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        checks++;
        if (res_valid !== 1'b0 || res_kind !== 2'd0 || res_early !== '0 || res_late !== '0) begin
            fails++;
            $display("FAIL R1 reset outputs: actual v%0b k%0d e%0d l%0d expected all zero",
                     res_valid, res_kind, res_early, res_late);
        end
        // Edge recorded, then reset before it is due: must never appear.
        odt = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b1; odt = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        got_n = 0;
        repeat (12) @(negedge clk);
        chk_count("R1 history cleared", 0);
    endtask

    task automatic t_sync_idle();
        int b;
        scen(0, -1, -1, -1, 2, 5, 16, b);
        chk_count("R2", 2);
        chk_res(0, "R2 R8 sync rise", 0, 1, 4, 5, b + 2 + WL);
        chk_res(1, "R2 R3 sync fall", 0, 0, 4, 5, b + 5 + WL);
    endtask

    task automatic t_window_start();
        int b;
        scen(0, 10, -1, -1, 5, 6, 20, b);
        chk_res(0, "R4 edge at window start stays sync", 0, 1, 4, 5, b + 5 + WL);
        chk_res(1, "R4 R8 retroactive uncertain fall", 1, 0, 4, 10, b + 6 + WL);
    endtask

    task automatic t_edge_at_fall();
        int b;
        scen(0, 5, -1, -1, 5, -1, 15, b);
        chk_count("R4 edge at fall", 1);
        chk_res(0, "R4 R8 edge in fall cycle uncertain", 1, 1, 4, 9, b + 5 + WL);
    endtask

    task automatic t_window_end();
        int b;
        scen(0, 5, -1, -1, 8, 9, 20, b);
        chk_res(0, "R5 last window cycle uncertain", 1, 1, 4, 9, b + 8 + WL);
        chk_res(1, "R5 R8 after window async", 2, 0, 6, 10, b + 9 + WL);
    endtask

    task automatic t_refresh_ext();
        int b;
        scen(0, 12, -1, 2, 22, 23, 32, b);
        chk_res(0, "R6 refresh-extended end uncertain", 1, 1, 4, 9, b + 22 + WL);
        chk_res(1, "R6 past refresh end async", 2, 0, 6, 10, b + 23 + WL);
    endtask

    task automatic t_refresh_done();
        int b;
        scen(0, 25, -1, 0, 29, -1, 40, b);
        chk_count("R6 finished refresh", 1);
        chk_res(0, "R6 finished refresh no extension", 2, 1, 6, 9, b + 29 + WL);
    endtask

    task automatic t_dll_on();
        int b;
        scen(1, 10, -1, -1, 8, 12, 22, b);
        chk_res(0, "R7 dll on before fall sync", 0, 1, 4, 5, b + 8 + WL);
        chk_res(1, "R7 dll on after fall sync", 0, 0, 4, 5, b + 12 + WL);
    endtask

    task automatic t_exit();
        int b;
        scen(0, 5, 12, -1, 20, -1, 30, b);
        chk_count("R9 after exit", 1);
        chk_res(0, "R9 edge after cke high sync", 0, 1, 4, 5, b + 20 + WL);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        t_reset_state();
        t_sync_idle();
        t_window_start();
        t_edge_at_fall();
        t_window_end();
        t_refresh_ext();
        t_refresh_done();
        t_dll_on();
        t_exit();
        summary();
        $finish;
    end

endmodule